// File: doc/BRIEF.md
# Processor Status Mode and Privilege Trap Unit

This block holds the writable mode bits at the top of a minicomputer status word and the trap path that depends on them. Three flip-flops hold status bits 15..13; bit 15 high means user mode. The low status bits come from condition-code logic outside the block and are only read here.

An instruction register is decoded together with the current mode. The halt, wait and reset opcodes are privileged. In kernel mode each gets its own class code. In user mode each becomes an illegal instruction, which raises a trap. While the trap is active, the internal data bus carries the fixed illegal-instruction vector in place of whatever the microcode select would pass. Entering the halted state clears the instruction register and forces kernel mode.

A console-style port reaches the program counter and the status word by bus address, using a deposit strobe and an examine strobe. The status-load strobe is decoded from the address, so a deposit to the program counter never reaches the status bits. The status bits take new data on the rising edge of that internal strobe.

Top module: `stp_core`

## Requirements
- R1: While reset is held, and after it is released, the status bits are 000 (kernel mode), the program counter and instruction register are 0, and read data is 0 with read-valid low.
- R2: A deposit to address 777707 (octal) loads the program counter one cycle later. Repeated deposits of 177777 read back 177777 every time and leave the mode bits unchanged.
- R3: A deposit to address 777776 (octal) loads status bits 15..13 from write-data bits 15..13 two cycles after the strobe. A read of the status word returns the mode bits in 15..13, zero in 12..4 and the condition-code input in 3..0.
- R4: The status bits load only on a low-to-high edge of the internal load strobe. When deposits to the status address are held over two consecutive cycles, only the first value is taken.
- R5: User mode is signalled exactly when status bit 15 is 1.
- R6: The class output is 3'b000 for an ordinary opcode. Opcode 0 (halt) gives 3'b010 in kernel mode. Opcodes 1 and 5 give 3'b011 in kernel mode. Any of the three in user mode gives 3'b001 (illegal).
- R7: When the class is 3'b001, the trap output is high and the data bus carries 000010 (octal) whatever the bus select is.
- R8: Without a trap, the data bus carries the ALU input for select 2'b00, the auxiliary input for 2'b01, the status word for 2'b10 and the program counter for 2'b11.
- R9: A halt-entry pulse clears the instruction register and the status bits. It has priority over a status load edge or an instruction load in the same cycle.
- R10: An examine returns the addressed register on the read-data port one cycle after the strobe, with read-valid high for that one cycle. If a deposit to the same address falls in the same cycle, the examine returns the value from before the deposit. An unmapped address reads 0, and a deposit to it changes nothing.
- R11: A step request adds 2 to the program counter. A deposit to the program counter in the same cycle wins over the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| con_addr | input | 18 | Console bus address |
| con_wdata | input | 16 | Deposit data |
| con_dep | input | 1 | Deposit strobe |
| con_exam | input | 1 | Examine strobe |
| con_rdata | output | 16 | Examine result |
| con_rvalid | output | 1 | Examine result valid, one cycle |
| pc_step | input | 1 | Advance the program counter by 2 |
| ir_load | input | 1 | Load the instruction register |
| ir_in | input | 16 | Instruction register load value |
| halt_enter | input | 1 | Enter halted state: clear IR, force kernel mode |
| cc_in | input | 4 | Condition-code bits for status bits 3..0 |
| alu_in | input | 16 | ALU result |
| aux_in | input | 16 | Auxiliary bus source |
| bus_sel | input | 2 | Data bus source select |
| dbus | output | 16 | Internal data bus |
| mode_bits | output | 3 | Status bits 15..13 |
| user_mode | output | 1 | Current mode is user |
| ir_class | output | 3 | Instruction class code |
| trap_active | output | 1 | Illegal-instruction trap in progress |

## Verification
A halt entry and a status load edge can land on the same clock edge. The bench provokes this by issuing a status deposit and raising halt entry one cycle later, so that the load edge and the clear meet. It then judges the result by requiring kernel mode, and by requiring that a later deposit still loads. An examine and a deposit to the same register in the same cycle are also driven together; the read must show the old value and a second examine the new one. A trap against every bus select is also covered by the vector table.

// File: rtl/stp_pkg.sv
package stp_pkg;

  typedef enum logic [2:0] {
    CLS_NORMAL  = 3'b000,
    CLS_ILLEGAL = 3'b001,
    CLS_HALT    = 3'b010,
    CLS_PRIV    = 3'b011
  } ir_class_e;

  typedef enum logic [1:0] {
    SEL_ALU    = 2'b00,
    SEL_AUX    = 2'b01,
    SEL_STATUS = 2'b10,
    SEL_PC     = 2'b11
  } bus_sel_e;

  localparam int unsigned PRIV_OPS = 3;
  localparam logic [15:0] PRIV_OPCODE [PRIV_OPS] = '{16'o000000, 16'o000001, 16'o000005};

endpackage

// File: rtl/stp_console.sv
module stp_console #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 18,
  parameter logic [ADDR_W-1:0] PC_ADDR  = 18'o777707,
  parameter logic [ADDR_W-1:0] ST_ADDR  = 18'o777776,
  parameter int unsigned PC_STEP  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] con_addr,
  input  logic [DATA_W-1:0] con_wdata,
  input  logic              con_dep,
  input  logic              con_exam,
  input  logic              pc_step,
  input  logic [DATA_W-1:0] status_word,
  output logic [DATA_W-1:0] pc_q,
  output logic              stat_ld,
  output logic [DATA_W-1:0] stat_ld_data,
  output logic [DATA_W-1:0] con_rdata,
  output logic              con_rvalid
);

  localparam logic [DATA_W-1:0] STEP_V = DATA_W'(PC_STEP);

  logic              hit_pc, hit_st;
  logic              pc_en, ld_en, rd_en;
  logic [DATA_W-1:0] pc_d, ld_data_d, rdata_d;
  logic              ld_d;

  always_comb begin
    hit_pc    = (con_addr == PC_ADDR);
    hit_st    = (con_addr == ST_ADDR);
    pc_en     = (con_dep && hit_pc) || pc_step;
    pc_d      = (con_dep && hit_pc) ? con_wdata : pc_q + STEP_V;
    ld_d      = con_dep && hit_st;
    ld_en     = ld_d;
    ld_data_d = con_wdata;
    rd_en     = con_exam;
    if (hit_pc)      rdata_d = pc_q;
    else if (hit_st) rdata_d = status_word;
    else             rdata_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q         <= '0;
      stat_ld      <= 1'b0;
      stat_ld_data <= '0;
      con_rdata    <= '0;
      con_rvalid   <= 1'b0;
    end else begin
      stat_ld    <= ld_d;
      con_rvalid <= con_exam;
      if (pc_en) pc_q         <= pc_d;
      if (ld_en) stat_ld_data <= ld_data_d;
      if (rd_en) con_rdata    <= rdata_d;
    end
  end

endmodule

// File: rtl/stp_status.sv
module stp_status #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_strobe,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              halt_enter,
  output logic [MODE_W-1:0] mode_q
);

  logic              strobe_prev;
  logic              ld_rise;
  logic              mode_en;
  logic [MODE_W-1:0] mode_d;

  always_comb begin
    ld_rise = ld_strobe && !strobe_prev;
    mode_en = halt_enter || ld_rise;
    mode_d  = halt_enter ? '0 : ld_data[DATA_W-1 -: MODE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_prev <= 1'b0;
      mode_q      <= '0;
    end else begin
      strobe_prev <= ld_strobe;
      if (mode_en) mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/stp_decode.sv
module stp_decode
  import stp_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_load,
  input  logic [DATA_W-1:0] ir_in,
  input  logic              halt_enter,
  input  logic              user_mode,
  output logic [DATA_W-1:0] ir_q,
  output ir_class_e         ir_class,
  output logic              illegal
);

  logic              ir_en;
  logic [DATA_W-1:0] ir_d;
  logic              is_halt, is_priv;

  always_comb begin
    ir_en = ir_load || halt_enter;
    ir_d  = halt_enter ? '0 : ir_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ir_q <= '0;
    else if (ir_en) ir_q <= ir_d;
  end

  always_comb begin
    is_halt = (ir_q == DATA_W'(PRIV_OPCODE[0]));
    is_priv = 1'b0;
    for (int i = 0; i < PRIV_OPS; i++) begin
      if (ir_q == DATA_W'(PRIV_OPCODE[i])) is_priv = 1'b1;
    end
    if (is_priv && user_mode) ir_class = CLS_ILLEGAL;
    else if (is_halt)         ir_class = CLS_HALT;
    else if (is_priv)         ir_class = CLS_PRIV;
    else                      ir_class = CLS_NORMAL;
    illegal = (ir_class == CLS_ILLEGAL);
  end

endmodule

// File: rtl/stp_core.sv
module stp_core
  import stp_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned ADDR_W  = 18,
  parameter int unsigned MODE_W  = 3,
  parameter int unsigned CC_W    = 4,
  parameter logic [ADDR_W-1:0] PC_ADDR = 18'o777707,
  parameter logic [ADDR_W-1:0] ST_ADDR = 18'o777776,
  parameter logic [DATA_W-1:0] TRAP_VEC = 16'o000010,
  parameter int unsigned PC_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] con_addr,
  input  logic [DATA_W-1:0] con_wdata,
  input  logic              con_dep,
  input  logic              con_exam,
  output logic [DATA_W-1:0] con_rdata,
  output logic              con_rvalid,
  input  logic              pc_step,
  input  logic              ir_load,
  input  logic [DATA_W-1:0] ir_in,
  input  logic              halt_enter,
  input  logic [CC_W-1:0]   cc_in,
  input  logic [DATA_W-1:0] alu_in,
  input  logic [DATA_W-1:0] aux_in,
  input  logic [1:0]        bus_sel,
  output logic [DATA_W-1:0] dbus,
  output logic [MODE_W-1:0] mode_bits,
  output logic              user_mode,
  output logic [2:0]        ir_class,
  output logic              trap_active
);

  localparam int unsigned PAD_W = DATA_W - MODE_W - CC_W;

  logic [1:0]        rst_sync;
  logic              rst_q_n;
  logic [DATA_W-1:0] pc_q, stat_ld_data, status_word, ir_q, sel_bus;
  logic              stat_ld, illegal;
  ir_class_e         cls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  stp_console #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PC_ADDR(PC_ADDR),
    .ST_ADDR(ST_ADDR), .PC_STEP(PC_STEP)
  ) u_con (
    .clk(clk), .rst_n(rst_q_n), .con_addr(con_addr), .con_wdata(con_wdata),
    .con_dep(con_dep), .con_exam(con_exam), .pc_step(pc_step),
    .status_word(status_word), .pc_q(pc_q), .stat_ld(stat_ld),
    .stat_ld_data(stat_ld_data), .con_rdata(con_rdata), .con_rvalid(con_rvalid)
  );

  stp_status #(.DATA_W(DATA_W), .MODE_W(MODE_W)) u_st (
    .clk(clk), .rst_n(rst_q_n), .ld_strobe(stat_ld), .ld_data(stat_ld_data),
    .halt_enter(halt_enter), .mode_q(mode_bits)
  );

  stp_decode #(.DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst_n(rst_q_n), .ir_load(ir_load), .ir_in(ir_in),
    .halt_enter(halt_enter), .user_mode(user_mode), .ir_q(ir_q),
    .ir_class(cls), .illegal(illegal)
  );

  always_comb begin
    user_mode   = mode_bits[MODE_W-1];
    status_word = {mode_bits, {PAD_W{1'b0}}, cc_in};
    ir_class    = cls;
    trap_active = illegal;
    case (bus_sel_e'(bus_sel))
      SEL_ALU:    sel_bus = alu_in;
      SEL_AUX:    sel_bus = aux_in;
      SEL_STATUS: sel_bus = status_word;
      default:    sel_bus = pc_q;
    endcase
    dbus = trap_active ? TRAP_VEC : sel_bus;
  end

endmodule

// File: rtl/stp_core_chk.sv
module stp_core_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned MODE_W = 3,
  parameter logic [ADDR_W-1:0] PC_ADDR = 18'o777707,
  parameter logic [DATA_W-1:0] TRAP_VEC = 16'o000010
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic [ADDR_W-1:0] con_addr,
  input logic              con_dep,
  input logic              stat_ld,
  input logic              halt_enter,
  input logic [MODE_W-1:0] mode_bits,
  input logic              user_mode,
  input logic [DATA_W-1:0] ir_q,
  input logic [2:0]        ir_class,
  input logic              trap_active,
  input logic [DATA_W-1:0] dbus,
  input logic [DATA_W-1:0] alu_in,
  input logic [1:0]        bus_sel
);

  logic ld_seen;
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) ld_seen <= 1'b0;
    else          ld_seen <= stat_ld;
  end

  a_r2_pc_dep_no_status_load: assert property (@(posedge clk) disable iff (!rst_q_n)
    (con_dep && con_addr == PC_ADDR) |=> !stat_ld);

  a_r4_mode_holds_without_edge: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!halt_enter && !(stat_ld && !ld_seen)) |=> $stable(mode_bits));

  a_r6_user_halt_illegal: assert property (@(posedge clk) disable iff (!rst_q_n)
    (user_mode && ir_q == '0) |-> ir_class == 3'b001);

  a_r7_trap_vector_on_bus: assert property (@(posedge clk) disable iff (!rst_q_n)
    trap_active |-> dbus == TRAP_VEC);

  a_r8_alu_when_no_trap: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!trap_active && bus_sel == 2'b00) |-> dbus == alu_in);

  a_r9_halt_clears: assert property (@(posedge clk) disable iff (!rst_q_n)
    halt_enter |=> (mode_bits == '0 && ir_q == '0));

endmodule

bind stp_core stp_core_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MODE_W(MODE_W),
  .PC_ADDR(PC_ADDR), .TRAP_VEC(TRAP_VEC)
) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .con_addr(con_addr), .con_dep(con_dep),
  .stat_ld(stat_ld), .halt_enter(halt_enter), .mode_bits(mode_bits),
  .user_mode(user_mode), .ir_q(ir_q), .ir_class(ir_class),
  .trap_active(trap_active), .dbus(dbus), .alu_in(alu_in), .bus_sel(bus_sel)
);

// File: tb/stp_core_bench.sv
module stp_core_bench;

  localparam logic [17:0] A_PC = 18'o777707;
  localparam logic [17:0] A_ST = 18'o777776;
  localparam logic [17:0] A_NONE = 18'o777700;
  localparam logic [15:0] ALU_V = 16'o123456;
  localparam logic [15:0] AUX_V = 16'o054321;
  localparam logic [3:0]  CC_V  = 4'b1010;
  localparam logic [15:0] PC_V  = 16'o001000;

  // {user, ir, sel, class, trap, dbus}
  localparam logic [38:0] VEC [10] = '{
    {1'b0, 16'o000240, 2'd0, 3'b000, 1'b0, 16'o123456},
    {1'b0, 16'o012700, 2'd1, 3'b000, 1'b0, 16'o054321},
    {1'b0, 16'o000000, 2'd2, 3'b010, 1'b0, 16'o000012},
    {1'b0, 16'o000001, 2'd3, 3'b011, 1'b0, 16'o001000},
    {1'b0, 16'o000005, 2'd0, 3'b011, 1'b0, 16'o123456},
    {1'b1, 16'o000000, 2'd0, 3'b001, 1'b1, 16'o000010},
    {1'b1, 16'o000001, 2'd2, 3'b001, 1'b1, 16'o000010},
    {1'b1, 16'o000005, 2'd3, 3'b001, 1'b1, 16'o000010},
    {1'b1, 16'o000240, 2'd2, 3'b000, 1'b0, 16'o100012},
    {1'b1, 16'o012700, 2'd3, 3'b000, 1'b0, 16'o001000}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [17:0] con_addr;
  logic [15:0] con_wdata;
  logic        con_dep, con_exam;
  logic [15:0] con_rdata;
  logic        con_rvalid;
  logic        pc_step, ir_load, halt_enter;
  logic [15:0] ir_in;
  logic [15:0] dbus;
  logic [2:0]  mode_bits, ir_class;
  logic        user_mode, trap_active;
  logic [1:0]  bus_sel;

  int checks = 0;
  int errors = 0;
  logic [15:0] rd;

  always #5 clk = ~clk;

  stp_core u_stp_core (
    .clk(clk), .rst_n(rst_n), .con_addr(con_addr), .con_wdata(con_wdata),
    .con_dep(con_dep), .con_exam(con_exam), .con_rdata(con_rdata),
    .con_rvalid(con_rvalid), .pc_step(pc_step), .ir_load(ir_load),
    .ir_in(ir_in), .halt_enter(halt_enter), .cc_in(CC_V), .alu_in(ALU_V),
    .aux_in(AUX_V), .bus_sel(bus_sel), .dbus(dbus), .mode_bits(mode_bits),
    .user_mode(user_mode), .ir_class(ir_class), .trap_active(trap_active)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%o expected=%o", tag, act, exp);
    end
  endtask

  task automatic deposit(input logic [17:0] a, input logic [15:0] d);
    @(negedge clk); con_dep = 1'b1; con_addr = a; con_wdata = d;
    @(negedge clk); con_dep = 1'b0;
    @(negedge clk);
  endtask

  task automatic examine(input logic [17:0] a, output logic [15:0] d);
    @(negedge clk); con_exam = 1'b1; con_addr = a;
    @(negedge clk); con_exam = 1'b0;
    d = con_rdata;
    check("R10 rvalid after examine", {15'd0, con_rvalid}, 16'd1);
  endtask

  task automatic load_ir(input logic [15:0] v);
    @(negedge clk); ir_load = 1'b1; ir_in = v;
    @(negedge clk); ir_load = 1'b0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic cur_user;
    rst_n = 1'b0; con_addr = '0; con_wdata = '0; con_dep = 1'b0; con_exam = 1'b0;
    pc_step = 1'b0; ir_load = 1'b0; ir_in = '0; halt_enter = 1'b0; bus_sel = 2'd0;
    repeat (4) @(negedge clk);
    check("R1 mode in reset", {13'd0, mode_bits}, 16'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 mode after reset", {13'd0, mode_bits}, 16'd0);
    check("R1 rvalid", {15'd0, con_rvalid}, 16'd0);
    check("R1 rdata", con_rdata, 16'd0);
    check("R1 ir halt class kernel", {13'd0, ir_class}, 16'b010);
    examine(A_PC, rd); check("R1 pc zero", rd, 16'd0);
    examine(A_ST, rd); check("R3 status word after reset", rd, 16'o000012);

    // vector table: R6 R7 R8 R5
    deposit(A_PC, PC_V);
    cur_user = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (VEC[i][38] != cur_user) begin
        deposit(A_ST, VEC[i][38] ? 16'o100000 : 16'o000000);
        cur_user = VEC[i][38];
      end
      bus_sel = VEC[i][21:20];
      load_ir(VEC[i][37:22]);
      check($sformatf("R5 user mode vec%0d", i), {15'd0, user_mode}, {15'd0, VEC[i][38]});
      check($sformatf("R6 class vec%0d", i), {13'd0, ir_class}, {13'd0, VEC[i][19:17]});
      check($sformatf("R7 trap vec%0d", i), {15'd0, trap_active}, {15'd0, VEC[i][16]});
      check($sformatf("R8 dbus vec%0d", i), dbus, VEC[i][15:0]);
    end

    // R2: repeated all-ones deposits to PC
    bus_sel = 2'd0;
    for (int k = 0; k < 3; k++) begin
      deposit(A_PC, 16'o177777);
      examine(A_PC, rd);
      check("R2 pc readback", rd, 16'o177777);
      check("R2 mode untouched", {13'd0, mode_bits}, 16'b100);
    end

    // R3: status deposit
    deposit(A_ST, 16'o177777);
    examine(A_ST, rd);
    check("R3 status readback", rd, 16'o160012);
    check("R5 user mode set", {15'd0, user_mode}, 16'd1);
    load_ir(16'o000000);
    check("R7 halt in user traps", {15'd0, trap_active}, 16'd1);
    check("R7 vector on bus", dbus, 16'o000010);

    // R9: halt entry
    @(negedge clk); halt_enter = 1'b1;
    @(negedge clk); halt_enter = 1'b0;
    check("R9 mode cleared", {13'd0, mode_bits}, 16'd0);
    check("R9 ir cleared kernel halt class", {13'd0, ir_class}, 16'b010);
    check("R9 alu back on bus", dbus, ALU_V);
    // R9: halt meets status load edge
    @(negedge clk); con_dep = 1'b1; con_addr = A_ST; con_wdata = 16'o100000;
    @(negedge clk); con_dep = 1'b0; halt_enter = 1'b1;
    @(negedge clk); halt_enter = 1'b0;
    @(negedge clk);
    check("R9 halt wins over load", {13'd0, mode_bits}, 16'd0);
    load_ir(16'o012700);
    @(negedge clk); ir_load = 1'b1; ir_in = 16'o000240; halt_enter = 1'b1;
    @(negedge clk); ir_load = 1'b0; halt_enter = 1'b0;
    check("R9 halt wins over ir load", {13'd0, ir_class}, 16'b010);
    deposit(A_ST, 16'o040000);
    check("R9 later load still works", {13'd0, mode_bits}, 16'b010);

    // R4: held strobe loads once
    @(negedge clk); halt_enter = 1'b1;
    @(negedge clk); halt_enter = 1'b0;
    con_dep = 1'b1; con_addr = A_ST; con_wdata = 16'o100000;
    @(negedge clk); con_wdata = 16'o040000;
    @(negedge clk); con_dep = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R4 only first of held deposits", {13'd0, mode_bits}, 16'b100);

    // R10: examine with same-cycle deposit, unmapped address
    @(negedge clk); con_dep = 1'b1; con_exam = 1'b1; con_addr = A_PC; con_wdata = 16'o000777;
    @(negedge clk); con_dep = 1'b0; con_exam = 1'b0;
    check("R10 examine sees old pc", con_rdata, 16'o177777);
    @(negedge clk);
    check("R10 rvalid one cycle", {15'd0, con_rvalid}, 16'd0);
    examine(A_PC, rd); check("R10 new pc after", rd, 16'o000777);
    deposit(A_NONE, 16'o177777);
    examine(A_PC, rd); check("R10 unmapped dep leaves pc", rd, 16'o000777);
    examine(A_ST, rd); check("R10 unmapped dep leaves status", rd, 16'o100012);
    examine(A_NONE, rd); check("R10 unmapped reads zero", rd, 16'd0);

    // R11: step
    deposit(A_PC, 16'o000100);
    @(negedge clk); pc_step = 1'b1;
    @(negedge clk); pc_step = 1'b0;
    examine(A_PC, rd); check("R11 step adds 2", rd, 16'o000102);
    @(negedge clk); pc_step = 1'b1; con_dep = 1'b1; con_addr = A_PC; con_wdata = 16'o002000;
    @(negedge clk); pc_step = 1'b0; con_dep = 1'b0;
    examine(A_PC, rd); check("R11 deposit wins over step", rd, 16'o002000);

    finish_run();
  end

endmodule